// File: doc/BRIEF.md
# Dual-channel DAC input latch model

This block is a cycle-accurate digital model of the input side of a two-channel parallel digital-to-analog converter. Every channel is double-buffered: an input register takes a code from a data port, and a converter register takes the input register's value when that channel's update clock rises. The converter-register codes are presented as a true output and as its bitwise complement. In this model the complement stands for the second, complementary current output.

A mode input picks one of two behaviours. In dual mode each channel has its own data port, its own write strobe and its own update clock, and the channels do not interact. In interleaved mode the four control pins take new roles. One data port feeds both channels, and a select level decides which input register a write loads. One update clock is divided by two to update both converter registers together. A level input holds that divider in its reset state, and this lets the surrounding logic line up the update phase with the data routing.

Every strobe and clock pin is sampled by one fast system clock. A rising edge is a pin that is high now and was low one sample earlier. The mode is captured once, in the first system clock after reset is released.

Top module: `dual_dac_latch`

## Requirements
- R1: While rst_ni is low, both converter codes read 0x00 and both complement outputs read 0xFF. A rise on an update pin that comes after reset, with no write strobe before it, moves 0x00 from the input registers into the converter registers.
- R2: mode_i is sampled in the first clk_i cycle after reset is released. The value 1 selects dual mode and 0 selects interleaved mode. Later changes of mode_i have no effect until the next reset.
- R3: In dual mode, a rising edge on wr_a_i (wr_b_i) loads port_a_i (port_b_i) into that channel's input register. The converter code does not change because of a write.
- R4: In dual mode, a rising edge on upd_a_i (upd_b_i) copies that channel's input register into its converter register. Strobes of one channel never change the other channel's codes.
- R5: When a write rise and an update rise of the same channel come in the same cycle, the converter register takes the input register's value from before that write.
- R6: comp_a_o and comp_b_o are always the bitwise inverse of code_a_o and code_b_o. Codes are 8-bit straight binary with bit 7 as the MSB.
- R7: In interleaved mode, a rising edge on wr_a_i loads port_a_i into channel A's input register when wr_b_i is 1 and into channel B's input register when wr_b_i is 0. port_b_i is ignored.
- R8: In interleaved mode, while upd_b_i (the divider reset) is high, rising edges on upd_a_i update neither converter register.
- R9: In interleaved mode, the first rising edge of upd_a_i after reset, or after upd_b_i goes low, updates both converter registers at once. After that, only every other rising edge updates them.
- R10: Only edges act. A strobe held high loads once, and changes on the port while the strobe stays high are not captured.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System sampling clock, at least 4x the strobe rate |
| rst_ni | input | 1 | Active-low asynchronous reset |
| mode_i | input | 1 | 1 = dual, 0 = interleaved; sampled after reset |
| port_a_i | input | 8 | Data port A (the only data port in interleaved mode) |
| port_b_i | input | 8 | Data port B (dual mode only) |
| wr_a_i | input | 1 | Dual: write strobe A. Interleaved: shared write |
| wr_b_i | input | 1 | Dual: write strobe B. Interleaved: channel select |
| upd_a_i | input | 1 | Dual: update clock A. Interleaved: update clock, divided by two |
| upd_b_i | input | 1 | Dual: update clock B. Interleaved: divider reset, active high |
| code_a_o | output | 8 | Converter register code, channel A |
| code_b_o | output | 8 | Converter register code, channel B |
| comp_a_o | output | 8 | Complement of code_a_o |
| comp_b_o | output | 8 | Complement of code_b_o |

## Verification
The bench sweeps every 8-bit code through both channels in dual mode. It checks that a write alone leaves the converter code untouched: a design without the second buffer stage would show new data too early. The same-cycle write and update case catches a converter register that is fed from the port instead of from the old input register. Interleaved sweeps drive unrelated data on port B and change the select between writes, which exposes steering in the wrong direction or a leak from port B. A sequence through the divider reset checks the phase. A divider that does not return to its update phase, or one that updates on every edge, shows an update one edge too early or too late. The bench also flips mode_i after reset and holds strobes high, to show that the mode is latched and that capture acts on edges only.

// File: rtl/dac_latch_pkg.sv
package dac_latch_pkg;
  localparam int unsigned CODE_W = 8;
  localparam int unsigned NUM_CH = 2;
  localparam int unsigned NUM_STB = 4;

  typedef enum logic {
    MODE_ILV  = 1'b0,
    MODE_DUAL = 1'b1
  } dac_mode_e;

  // strobe bit positions in the sampled vector
  localparam int unsigned STB_WR_A  = 0;
  localparam int unsigned STB_WR_B  = 1;
  localparam int unsigned STB_UPD_A = 2;
  localparam int unsigned STB_UPD_B = 3;
endpackage

// File: rtl/rise_det.sv
module rise_det #(
  parameter int unsigned N = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] sig_i,
  output logic [N-1:0] rise_o
);
  logic [N-1:0] prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= '0;
    else         prev_q <= sig_i;
  end

  assign rise_o = sig_i & ~prev_q;
endmodule

// File: rtl/latch_pair.sv
module latch_pair #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] din_i,
  input  logic         xfer_i,
  output logic [W-1:0] code_o
);
  logic [W-1:0] in_q, conv_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      in_q   <= '0;
      conv_q <= '0;
    end else begin
      if (load_i) in_q   <= din_i;
      if (xfer_i) conv_q <= in_q;   // pre-write value on a same-cycle load
    end
  end

  assign code_o = conv_q;
endmodule

// File: rtl/iq_phase.sv
module iq_phase (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic hold_i,
  input  logic edge_i,
  output logic upd_o,
  output logic phase_o
);
  logic phase_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              phase_q <= 1'b0;
    else if (!en_i || hold_i) phase_q <= 1'b0;
    else if (edge_i)          phase_q <= ~phase_q;
  end

  assign upd_o   = en_i & ~hold_i & edge_i & ~phase_q;
  assign phase_o = phase_q;
endmodule

// File: rtl/dual_dac_latch.sv
module dual_dac_latch
  import dac_latch_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              mode_i,
  input  logic [CODE_W-1:0] port_a_i,
  input  logic [CODE_W-1:0] port_b_i,
  input  logic              wr_a_i,
  input  logic              wr_b_i,
  input  logic              upd_a_i,
  input  logic              upd_b_i,
  output logic [CODE_W-1:0] code_a_o,
  output logic [CODE_W-1:0] code_b_o,
  output logic [CODE_W-1:0] comp_a_o,
  output logic [CODE_W-1:0] comp_b_o
);
  logic              started_q;
  dac_mode_e         mode_q;
  logic [NUM_STB-1:0] stb, rise;
  logic              ilv, iq_upd, iq_phase_w;
  logic [NUM_CH-1:0] load, xfer;
  logic [CODE_W-1:0] din  [NUM_CH];
  logic [CODE_W-1:0] code [NUM_CH];

  // mode captured once, first cycle out of reset
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      started_q <= 1'b0;
      mode_q    <= MODE_DUAL;
    end else if (!started_q) begin
      started_q <= 1'b1;
      mode_q    <= dac_mode_e'(mode_i);
    end
  end

  assign stb = {upd_b_i, upd_a_i, wr_b_i, wr_a_i};

  rise_det #(.N(NUM_STB)) u_rise (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .sig_i  (stb),
    .rise_o (rise)
  );

  assign ilv = started_q && (mode_q == MODE_ILV);

  iq_phase u_phase (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .en_i    (ilv),
    .hold_i  (upd_b_i),
    .edge_i  (rise[STB_UPD_A]),
    .upd_o   (iq_upd),
    .phase_o (iq_phase_w)
  );

  always_comb begin
    din[0] = port_a_i;
    din[1] = port_b_i;
    load   = '0;
    xfer   = '0;
    if (started_q) begin
      if (ilv) begin
        din[1]  = port_a_i;
        load[0] = rise[STB_WR_A] &  wr_b_i;
        load[1] = rise[STB_WR_A] & ~wr_b_i;
        xfer    = {NUM_CH{iq_upd}};
      end else begin
        load = {rise[STB_WR_B],  rise[STB_WR_A]};
        xfer = {rise[STB_UPD_B], rise[STB_UPD_A]};
      end
    end
  end

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    latch_pair #(.W(CODE_W)) u_lp (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .load_i (load[g]),
      .din_i  (din[g]),
      .xfer_i (xfer[g]),
      .code_o (code[g])
    );
  end

  assign code_a_o = code[0];
  assign code_b_o = code[1];
  assign comp_a_o = ~code[0];
  assign comp_b_o = ~code[1];
endmodule

// File: rtl/dual_dac_latch_chk.sv
module dual_dac_latch_chk
  import dac_latch_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              ilv,
  input logic              started_q,
  input dac_mode_e         mode_q,
  input logic [NUM_CH-1:0] xfer,
  input logic              iq_phase_w,
  input logic [NUM_STB-1:0] rise,
  input logic              upd_b_i,
  input logic [CODE_W-1:0] code_a_o,
  input logic [CODE_W-1:0] code_b_o
);
  // R4
  code_a_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(code_a_o) |-> $past(xfer[0]));
  // R4
  code_b_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(code_b_o) |-> $past(xfer[1]));
  // R8
  div_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ilv && upd_b_i) |=> ($stable(code_a_o) && $stable(code_b_o)));
  // R9
  skip_edge_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ilv && !upd_b_i && rise[STB_UPD_A] && iq_phase_w) |=> ($stable(code_a_o) && $stable(code_b_o)));
  // R2
  mode_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    started_q |=> $stable(mode_q));
  // R10
  single_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise[STB_WR_A] |=> !rise[STB_WR_A]);
endmodule

bind dual_dac_latch dual_dac_latch_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .ilv        (ilv),
  .started_q  (started_q),
  .mode_q     (mode_q),
  .xfer       (xfer),
  .iq_phase_w (iq_phase_w),
  .rise       (rise),
  .upd_b_i    (upd_b_i),
  .code_a_o   (code_a_o),
  .code_b_o   (code_b_o)
);

// File: tb/dual_dac_latch_test.sv
module dual_dac_latch_test;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       mode_i = 1'b1;
  logic [7:0] port_a_i = '0, port_b_i = '0;
  logic       wr_a_i = 0, wr_b_i = 0, upd_a_i = 0, upd_b_i = 0;
  logic [7:0] code_a_o, code_b_o, comp_a_o, comp_b_o;
  int checks = 0, failures = 0;
  bit done = 0;

  always #10 clk_i = ~clk_i;

  dual_dac_latch uut (.*);

  task automatic tick();
    @(posedge clk_i); @(negedge clk_i);
  endtask

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s act=%02h exp=%02h", req, act, exp);
    end
  endtask

  task automatic do_reset(logic m);
    @(negedge clk_i);
    rst_ni = 0; mode_i = m;
    {wr_a_i, wr_b_i, upd_a_i, upd_b_i} = '0;
    tick();
    rst_ni = 1;
    tick();
  endtask

  task automatic pulse_wr_a(); wr_a_i = 1; tick(); wr_a_i = 0; tick(); endtask
  task automatic pulse_wr_b(); wr_b_i = 1; tick(); wr_b_i = 0; tick(); endtask
  task automatic pulse_upd_a(); upd_a_i = 1; tick(); upd_a_i = 0; tick(); endtask
  task automatic pulse_upd_b(); upd_b_i = 1; tick(); upd_b_i = 0; tick(); endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    // R1 reset state
    @(negedge clk_i);
    chk("R1 code_a", code_a_o, 8'h00);
    chk("R1 code_b", code_b_o, 8'h00);
    chk("R1 comp_a", comp_a_o, 8'hFF);
    chk("R1 comp_b", comp_b_o, 8'hFF);
    do_reset(1'b1);
    port_a_i = 8'h3C; pulse_upd_a();
    chk("R1 xfer zero", code_a_o, 8'h00);

    // R3 R4 R6 dual sweep over all codes
    for (int v = 0; v < 256; v++) begin
      logic [7:0] pa, pb, oa, ob;
      pa = 8'(v); pb = 8'(255 - v);
      oa = code_a_o; ob = code_b_o;
      port_a_i = pa; port_b_i = pb;
      pulse_wr_a(); pulse_wr_b();
      port_a_i = ~pa; port_b_i = ~pb;
      if (v % 16 == 0) begin
        chk("R3 write only a", code_a_o, oa);
        chk("R3 write only b", code_b_o, ob);
      end
      pulse_upd_a();
      chk("R4 upd a", code_a_o, pa);
      chk("R4 b untouched", code_b_o, ob);
      chk("R6 comp a", comp_a_o, ~pa);
      pulse_upd_b();
      chk("R4 upd b", code_b_o, pb);
      chk("R6 comp b", comp_b_o, ~pb);
    end

    // R5 same-cycle write and update
    port_a_i = 8'h11; pulse_wr_a(); pulse_upd_a();
    port_a_i = 8'h22; wr_a_i = 1; upd_a_i = 1; tick(); wr_a_i = 0; upd_a_i = 0; tick();
    chk("R5 old value", code_a_o, 8'h11);
    pulse_upd_a();
    chk("R5 new value", code_a_o, 8'h22);

    // R10 held strobe captures once
    port_a_i = 8'h5A; wr_a_i = 1; tick();
    port_a_i = 8'hA5; tick(); tick(); wr_a_i = 0; tick();
    pulse_upd_a();
    chk("R10 held write", code_a_o, 8'h5A);
    upd_a_i = 1; tick(); pulse_wr_a(); tick(); upd_a_i = 0; tick();
    chk("R10 held update", code_a_o, 8'h5A);

    // R2 mode change after reset ignored: upd_a must stay channel-A only
    port_b_i = 8'h77; pulse_wr_b(); pulse_upd_b();
    mode_i = 1'b0;
    port_a_i = 8'h44; wr_b_i = 1; pulse_wr_a(); wr_b_i = 0; tick();
    pulse_upd_a();
    chk("R2 dual held a", code_a_o, 8'h44);
    chk("R2 dual held b", code_b_o, 8'h77);

    // interleaved steering sweep
    do_reset(1'b0);
    for (int v = 0; v < 256; v += 3) begin
      logic [7:0] da, db;
      da = 8'(v); db = 8'(v) ^ 8'h5A;
      port_b_i = 8'(v * 7 + 1);
      wr_b_i = 1; tick();
      port_a_i = da; pulse_wr_a();
      wr_b_i = 0; tick();
      port_a_i = db; pulse_wr_a();
      port_a_i = 8'hEE;
      pulse_upd_b();                 // realign divider
      pulse_upd_a();                 // first edge: update
      chk("R7 steer a", code_a_o, da);
      chk("R7 steer b", code_b_o, db);
    end

    // R8 / R9 divider behaviour
    do_reset(1'b0);
    wr_b_i = 1; tick(); port_a_i = 8'h81; pulse_wr_a();
    wr_b_i = 0; tick(); port_a_i = 8'h18; pulse_wr_a();
    upd_b_i = 1; tick();
    pulse_upd_a(); pulse_upd_a();
    chk("R8 held a", code_a_o, 8'h00);
    chk("R8 held b", code_b_o, 8'h00);
    upd_b_i = 0; tick();
    pulse_upd_a();
    chk("R9 first edge a", code_a_o, 8'h81);
    chk("R9 first edge b", code_b_o, 8'h18);
    wr_b_i = 1; tick(); port_a_i = 8'hC3; pulse_wr_a(); wr_b_i = 0; tick();
    port_a_i = 8'h3C; pulse_wr_a();
    pulse_upd_a();
    chk("R9 skip a", code_a_o, 8'h81);
    chk("R9 skip b", code_b_o, 8'h18);
    pulse_upd_a();
    chk("R9 third a", code_a_o, 8'hC3);
    chk("R9 third b", code_b_o, 8'h3C);
    chk("R6 ilv comp", comp_b_o, 8'hC3);
    // divider reset mid-phase realigns
    pulse_upd_a();                   // skipped edge, phase now odd->even
    port_a_i = 8'h99; pulse_wr_a();  // sel=0 -> b
    pulse_upd_a();                   // update edge
    chk("R9 phase b", code_b_o, 8'h99);
    pulse_upd_a();                   // would be skipped
    pulse_upd_b();                   // realign
    port_a_i = 8'h66; pulse_wr_a();
    pulse_upd_a();
    chk("R9 realign b", code_b_o, 8'h66);

    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule